// File: doc/BRIEF.md
# GPIO Edge/Level Interrupt Controller

The block is an interrupt front end for three 8-bit GPIO ports, named A, B and F. Each pin can raise an interrupt on a high level, a low level, a rising edge or a falling edge. An optional per-pin filter rejects short glitches before the pin reaches the detector. A byte-wide register bus configures the block at fixed addresses and reads its state back. Each port also has an output data register and a direction register that drive its pads.

Ports A and B share one combined interrupt request. Port F has one request line per pin. Edge events are held until software clears them by writing ones to a clear register. Level conditions are not held: they follow the qualified pin. A port's enable register gates both its status and its request lines.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero, every interrupt output is low and every output-enable bit is low.
- R2: Each pin has a mode bit in type1 and a sense bit in type2. Mode 0 selects level detection and mode 1 selects edge detection. Sense 0 selects the low level or the falling edge, and sense 1 selects the high level or the rising edge. In level mode the status bit follows the pin while the pin is enabled and is never held.
- R3: In edge mode a status bit is set by the selected edge and stays set until it is cleared. The opposite edge does not set it.
- R4: A write to a port's clear register clears each held edge bit written as 1. Bits written as 0 keep their state. The clear register reads as zero.
- R5: Writing 0 to an enable bit removes that pin from the status register and from the request outputs at once, and discards any held edge. Setting the enable bit again does not bring the discarded edge back.
- R6: `irq_ab_o` is high exactly when any status bit of port A or of port B is set.
- R7: Bit k of `irq_f_o` equals status bit k of port F.
- R8: With its filter bit set, a pin reaches the detector only after it has held a new level for 4 consecutive sample ticks. One sample tick occurs every TICK_DIV clocks. A pulse shorter than one tick period never passes the filter. A pin without its filter bit passes after the 2-flop synchronizer only.
- R9: The data register drives the pad output and the direction register drives the pad output enable (1 = output). Reading the data address returns the data register bit for output pins and the synchronized pin for input pins.
- R10: Configuration addresses, listed as A/B/F: type1 0x90/0xAC/0x4C, type2 0x94/0xB0/0x50, clear 0x98/0xB4/0x54, enable 0x9C/0xB8/0x58, filter 0xA8/0xC4/0x64. Data is at 0x00/0x04/0x30 and direction at 0x10/0x14/0x34. Each register reads back the value last written.
- R11: The read-only status register of each port sits at 0xA0 for A, 0xBC for B and 0x5C for F. It returns the enabled status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | AW | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | W | Write data |
| bus_rdata_o | output | W | Read data for bus_addr_i, combinational |
| gpio_a_i | input | W | Port A pad inputs |
| gpio_a_o | output | W | Port A pad outputs |
| gpio_a_oe_o | output | W | Port A output enables |
| gpio_b_i | input | W | Port B pad inputs |
| gpio_b_o | output | W | Port B pad outputs |
| gpio_b_oe_o | output | W | Port B output enables |
| gpio_f_i | input | W | Port F pad inputs |
| gpio_f_o | output | W | Port F pad outputs |
| gpio_f_oe_o | output | W | Port F output enables |
| irq_ab_o | output | 1 | Combined request of ports A and B |
| irq_f_o | output | W | Per-pin requests of port F |

## Verification
A vector table drives the detection function on every port with level-high, level-low, rising-only, falling-only and mixed per-bit settings. Each vector uses bit patterns in which the pins that should fire and the pins that should not differ. This separates a swapped mode bit from a swapped sense bit, and it exposes a wrong edge direction. Directed sequences then hold an edge through the opposite transition, clear only part of the held bits, and drop and restore the enable bits. They also send a glitch to a filtered pin and an unfiltered pin side by side, so that each rule is seen apart from the others.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int NPORT = 3;  // index 0 = A, 1 = B, 2 = F
  localparam int PORT_F = 2;

  localparam logic [7:0] OFS_T1   [NPORT] = '{8'h90, 8'hAC, 8'h4C};
  localparam logic [7:0] OFS_T2   [NPORT] = '{8'h94, 8'hB0, 8'h50};
  localparam logic [7:0] OFS_EOI  [NPORT] = '{8'h98, 8'hB4, 8'h54};
  localparam logic [7:0] OFS_EN   [NPORT] = '{8'h9C, 8'hB8, 8'h58};
  localparam logic [7:0] OFS_STAT [NPORT] = '{8'hA0, 8'hBC, 8'h5C};
  localparam logic [7:0] OFS_DB   [NPORT] = '{8'hA8, 8'hC4, 8'h64};
  localparam logic [7:0] OFS_DATA [NPORT] = '{8'h00, 8'h04, 8'h30};
  localparam logic [7:0] OFS_DIR  [NPORT] = '{8'h10, 8'h14, 8'h34};

  typedef struct packed {
    logic t1;
    logic t2;
    logic eoi;
    logic en;
    logic db;
    logic data;
    logic dir;
  } wr_sel_t;
endpackage

// File: rtl/gpio_tick_gen.sv
module gpio_tick_gen #(
  parameter int TICK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  if (TICK_DIV <= 1) begin : g_every
    assign tick_o = 1'b1;
  end else begin : g_div
    localparam int CW = $clog2(TICK_DIV);
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          cnt_q <= '0;
      else if (cnt_q == CW'(TICK_DIV - 1))  cnt_q <= '0;
      else                                  cnt_q <= cnt_q + 1'b1;
    end
    assign tick_o = (cnt_q == CW'(TICK_DIV - 1));
  end
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter #(
  parameter int DB_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic db_en_i,
  input  logic pin_i,
  output logic sync_o,
  output logic filt_o
);
  localparam int CW = (DB_TICKS > 2) ? $clog2(DB_TICKS) : 1;

  logic          s1_q, s2_q;
  logic          stab_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end
  end

  // stability counter: counts ticks while sync differs from filtered level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stab_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!db_en_i) begin
      stab_q <= s2_q;
      cnt_q  <= '0;
    end else if (s2_q == stab_q) begin
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(DB_TICKS - 1)) begin
        stab_q <= s2_q;
        cnt_q  <= '0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign sync_o = s2_q;
  assign filt_o = db_en_i ? stab_q : s2_q;
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int W        = 8,
  parameter int DB_TICKS = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] pin_i,
  input  wr_sel_t      wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] t1_o,
  output logic [W-1:0] t2_o,
  output logic [W-1:0] en_o,
  output logic [W-1:0] db_o,
  output logic [W-1:0] data_o,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] rd_data_o,
  output logic [W-1:0] status_o
);
  logic [W-1:0] t1_q, t2_q, en_q, db_q, data_q, dir_q;
  logic [W-1:0] sync_w, filt_w, filt_q;
  logic [W-1:0] latch_q, latch_d, edge_hit, eoi_mask, level_st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t1_q   <= '0;
      t2_q   <= '0;
      en_q   <= '0;
      db_q   <= '0;
      data_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_i.t1)   t1_q   <= wdata_i;
      if (wr_i.t2)   t2_q   <= wdata_i;
      if (wr_i.en)   en_q   <= wdata_i;
      if (wr_i.db)   db_q   <= wdata_i;
      if (wr_i.data) data_q <= wdata_i;
      if (wr_i.dir)  dir_q  <= wdata_i;
    end
  end

  for (genvar k = 0; k < W; k++) begin : g_pin
    gpio_in_filter #(.DB_TICKS(DB_TICKS)) i_filt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (tick_i),
      .db_en_i(db_q[k]),
      .pin_i  (pin_i[k]),
      .sync_o (sync_w[k]),
      .filt_o (filt_w[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      filt_q  <= '0;
      latch_q <= '0;
    end else begin
      filt_q  <= filt_w;
      latch_q <= latch_d;
    end
  end

  always_comb begin
    edge_hit = (filt_w & ~filt_q & t2_q) | (~filt_w & filt_q & ~t2_q);
    eoi_mask = wr_i.eoi ? wdata_i : '0;
    // a new edge in the clearing cycle wins over the clear
    latch_d  = en_q & t1_q & ((latch_q & ~eoi_mask) | edge_hit);
    level_st = en_q & ~t1_q & ~(filt_w ^ t2_q);
  end

  assign status_o  = (latch_q & t1_q & en_q) | level_st;
  assign rd_data_o = (dir_q & data_q) | (~dir_q & sync_w);
  assign t1_o      = t1_q;
  assign t2_o      = t2_q;
  assign en_o      = en_q;
  assign db_o      = db_q;
  assign data_o    = data_q;
  assign dir_o     = dir_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W        = 8,
  parameter int AW       = 8,
  parameter int DB_TICKS = 4,
  parameter int TICK_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic [W-1:0]  bus_wdata_i,
  output logic [W-1:0]  bus_rdata_o,
  input  logic [W-1:0]  gpio_a_i,
  output logic [W-1:0]  gpio_a_o,
  output logic [W-1:0]  gpio_a_oe_o,
  input  logic [W-1:0]  gpio_b_i,
  output logic [W-1:0]  gpio_b_o,
  output logic [W-1:0]  gpio_b_oe_o,
  input  logic [W-1:0]  gpio_f_i,
  output logic [W-1:0]  gpio_f_o,
  output logic [W-1:0]  gpio_f_oe_o,
  output logic          irq_ab_o,
  output logic [W-1:0]  irq_f_o
);
  logic         tick_w;
  logic [W-1:0] pin_w    [NPORT];
  wr_sel_t      wr_w     [NPORT];
  logic [W-1:0] t1_w     [NPORT];
  logic [W-1:0] t2_w     [NPORT];
  logic [W-1:0] en_w     [NPORT];
  logic [W-1:0] db_w     [NPORT];
  logic [W-1:0] data_w   [NPORT];
  logic [W-1:0] dir_w    [NPORT];
  logic [W-1:0] rd_w     [NPORT];
  logic [W-1:0] status_w [NPORT];

  gpio_tick_gen #(.TICK_DIV(TICK_DIV)) i_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick_w)
  );

  assign pin_w[0] = gpio_a_i;
  assign pin_w[1] = gpio_b_i;
  assign pin_w[2] = gpio_f_i;

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_comb begin
      wr_w[p].t1   = bus_wr_i && (bus_addr_i == AW'(OFS_T1[p]));
      wr_w[p].t2   = bus_wr_i && (bus_addr_i == AW'(OFS_T2[p]));
      wr_w[p].eoi  = bus_wr_i && (bus_addr_i == AW'(OFS_EOI[p]));
      wr_w[p].en   = bus_wr_i && (bus_addr_i == AW'(OFS_EN[p]));
      wr_w[p].db   = bus_wr_i && (bus_addr_i == AW'(OFS_DB[p]));
      wr_w[p].data = bus_wr_i && (bus_addr_i == AW'(OFS_DATA[p]));
      wr_w[p].dir  = bus_wr_i && (bus_addr_i == AW'(OFS_DIR[p]));
    end

    gpio_irq_port #(.W(W), .DB_TICKS(DB_TICKS)) i_port (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .tick_i   (tick_w),
      .pin_i    (pin_w[p]),
      .wr_i     (wr_w[p]),
      .wdata_i  (bus_wdata_i),
      .t1_o     (t1_w[p]),
      .t2_o     (t2_w[p]),
      .en_o     (en_w[p]),
      .db_o     (db_w[p]),
      .data_o   (data_w[p]),
      .dir_o    (dir_w[p]),
      .rd_data_o(rd_w[p]),
      .status_o (status_w[p])
    );
  end

  always_comb begin
    bus_rdata_o = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (bus_addr_i == AW'(OFS_T1[p]))   bus_rdata_o = t1_w[p];
      if (bus_addr_i == AW'(OFS_T2[p]))   bus_rdata_o = t2_w[p];
      if (bus_addr_i == AW'(OFS_EN[p]))   bus_rdata_o = en_w[p];
      if (bus_addr_i == AW'(OFS_DB[p]))   bus_rdata_o = db_w[p];
      if (bus_addr_i == AW'(OFS_STAT[p])) bus_rdata_o = status_w[p];
      if (bus_addr_i == AW'(OFS_DATA[p])) bus_rdata_o = rd_w[p];
      if (bus_addr_i == AW'(OFS_DIR[p]))  bus_rdata_o = dir_w[p];
    end
  end

  assign gpio_a_o    = data_w[0];
  assign gpio_a_oe_o = dir_w[0];
  assign gpio_b_o    = data_w[1];
  assign gpio_b_oe_o = dir_w[1];
  assign gpio_f_o    = data_w[2];
  assign gpio_f_oe_o = dir_w[2];

  assign irq_ab_o = (|status_w[0]) | (|status_w[1]);
  assign irq_f_o  = status_w[PORT_F];
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int W  = 8,
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] bus_addr_i,
  input logic          bus_wr_i,
  input logic [W-1:0]  bus_wdata_i,
  input logic          irq_ab_o,
  input logic [W-1:0]  irq_f_o,
  input logic [W-1:0]  gpio_f_oe_o,
  input logic [W-1:0]  en_a_i,
  input logic [W-1:0]  en_b_i,
  input logic [W-1:0]  en_f_i,
  input logic [W-1:0]  edge_f_i
);
  // R5
  f_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_f_o & ~en_f_i) == '0);

  // R6
  ab_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_ab_o |-> ((en_a_i | en_b_i) != '0));

  // R9
  oe_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_addr_i == AW'(OFS_DIR[PORT_F])) |=> $stable(gpio_f_oe_o));

  for (genvar k = 0; k < W; k++) begin : g_bit
    // R3
    edge_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_f_o[k] && edge_f_i[k] &&
       !(bus_wr_i && bus_addr_i == AW'(OFS_EOI[PORT_F]) && bus_wdata_i[k]))
      |=> (irq_f_o[k] || !en_f_i[k] || !edge_f_i[k]));
  end
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(W), .AW(AW)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_addr_i (bus_addr_i),
  .bus_wr_i   (bus_wr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_ab_o   (irq_ab_o),
  .irq_f_o    (irq_f_o),
  .gpio_f_oe_o(gpio_f_oe_o),
  .en_a_i     (en_w[0]),
  .en_b_i     (en_w[1]),
  .en_f_i     (en_w[2]),
  .edge_f_i   (t1_w[2])
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  localparam time TCLK = 8ns;

  // register map per port (A, B, F)
  localparam logic [7:0] A_T1 [3] = '{8'h90, 8'hAC, 8'h4C};
  localparam logic [7:0] A_T2 [3] = '{8'h94, 8'hB0, 8'h50};
  localparam logic [7:0] A_CLR[3] = '{8'h98, 8'hB4, 8'h54};
  localparam logic [7:0] A_EN [3] = '{8'h9C, 8'hB8, 8'h58};
  localparam logic [7:0] A_ST [3] = '{8'hA0, 8'hBC, 8'h5C};
  localparam logic [7:0] A_DB [3] = '{8'hA8, 8'hC4, 8'h64};
  localparam logic [7:0] A_DAT[3] = '{8'h00, 8'h04, 8'h30};
  localparam logic [7:0] A_DIR[3] = '{8'h10, 8'h14, 8'h34};

  // {port[1:0], type1, type2, pins before, pins after, expected status}
  localparam int NVEC = 6;
  localparam logic [41:0] VEC [NVEC] = '{
    {2'd0, 8'h00, 8'hFF, 8'h00, 8'hA5, 8'hA5},  // level high
    {2'd0, 8'h00, 8'h00, 8'h00, 8'hA5, 8'h5A},  // level low
    {2'd1, 8'hFF, 8'hFF, 8'h0F, 8'hF0, 8'hF0},  // rising
    {2'd1, 8'hFF, 8'h00, 8'h0F, 8'hF0, 8'h0F},  // falling
    {2'd2, 8'hF0, 8'h0F, 8'hFF, 8'h3C, 8'hCC},  // mixed edge/level
    {2'd2, 8'hFF, 8'hAA, 8'h55, 8'hAA, 8'hFF}   // both directions per bit
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pa = '0, pb = '0, pf = '0;
  logic [7:0] a_o, a_oe, b_o, b_oe, f_o, f_oe, irq_f;
  logic       irq_ab;

  int n_chk = 0;
  int n_err = 0;

  always #(TCLK/2) clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_addr_i(bus_addr), .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata),
    .gpio_a_i(pa), .gpio_a_o(a_o), .gpio_a_oe_o(a_oe),
    .gpio_b_i(pb), .gpio_b_o(b_o), .gpio_b_oe_o(b_oe),
    .gpio_f_i(pf), .gpio_f_o(f_o), .gpio_f_oe_o(f_oe),
    .irq_ab_o(irq_ab), .irq_f_o(irq_f)
  );

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wait_clk(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic set_pins(int p, logic [7:0] v);
    if (p == 0) pa = v; else if (p == 1) pb = v; else pf = v;
  endtask

  task automatic all_off();
    for (int p = 0; p < 3; p++) wr(A_EN[p], 8'h00);
  endtask

  initial begin
    #(TCLK * 150000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    for (int p = 0; p < 3; p++) begin
      rd(A_ST[p], v);  chk("R1", "status after reset", v, 8'h00);
      rd(A_T1[p], v);  chk("R1", "type1 after reset", v, 8'h00);
      rd(A_EN[p], v);  chk("R1", "enable after reset", v, 8'h00);
    end
    chk("R1", "irq_ab after reset", {7'b0, irq_ab}, 8'h00);
    chk("R1", "irq_f after reset", irq_f, 8'h00);
    chk("R1", "oe after reset", a_oe | b_oe | f_oe, 8'h00);

    // vector table: R2 R3 R6 R7 R11
    for (int i = 0; i < NVEC; i++) begin
      int p;
      p = int'(VEC[i][41:40]);
      all_off();
      wr(A_T1[p], VEC[i][39:32]);
      wr(A_T2[p], VEC[i][31:24]);
      set_pins(p, VEC[i][23:16]);
      wait_clk(6);
      wr(A_EN[p], 8'hFF);
      wr(A_CLR[p], 8'hFF);
      set_pins(p, VEC[i][15:8]);
      wait_clk(6);
      rd(A_ST[p], v);
      chk("R2 R3 R11", $sformatf("vector %0d status", i), v, VEC[i][7:0]);
      if (p == 2)
        chk("R7", $sformatf("vector %0d irq_f", i), irq_f, VEC[i][7:0]);
      else
        chk("R6", $sformatf("vector %0d irq_ab", i), {7'b0, irq_ab},
            {7'b0, VEC[i][7:0] != 8'h00});
    end

    // R10 readback of configuration
    rd(A_T1[2], v); chk("R10", "type1 F readback", v, 8'hFF);
    rd(A_T2[2], v); chk("R10", "type2 F readback", v, 8'hAA);

    // directed: edge hold, partial clear, enable drop
    all_off();
    pa = 8'h00; pb = 8'h00; pf = 8'h00;
    wait_clk(6);
    wr(A_T1[0], 8'hFF);
    wr(A_T2[0], 8'hFF);
    wr(A_EN[0], 8'hFF);
    pa = 8'hFF;
    wait_clk(6);
    rd(A_ST[0], v); chk("R3", "rising latched", v, 8'hFF);
    chk("R6", "irq_ab from port A", {7'b0, irq_ab}, 8'h01);
    wr(A_CLR[0], 8'h0F);
    rd(A_ST[0], v); chk("R4", "partial clear", v, 8'hF0);
    rd(A_CLR[0], v); chk("R4", "clear reg reads zero", v, 8'h00);
    pa = 8'h00;
    wait_clk(6);
    rd(A_ST[0], v); chk("R3", "held through falling edge", v, 8'hF0);
    wr(A_EN[0], 8'h00);
    rd(A_ST[0], v); chk("R5", "disable removes status", v, 8'h00);
    chk("R5", "disable drops irq_ab", {7'b0, irq_ab}, 8'h00);
    wr(A_EN[0], 8'hFF);
    wait_clk(2);
    rd(A_ST[0], v); chk("R5", "discarded edge stays gone", v, 8'h00);
    wr(A_EN[0], 8'h00);

    // level is not held, enable masks level bits
    wr(A_T1[1], 8'h00);
    wr(A_T2[1], 8'hFF);
    wr(A_EN[1], 8'h3C);
    pb = 8'hFF;
    wait_clk(4);
    rd(A_ST[1], v); chk("R2", "level high masked by enable", v, 8'h3C);
    pb = 8'h00;
    wait_clk(4);
    rd(A_ST[1], v); chk("R2", "level released", v, 8'h00);
    chk("R6", "irq_ab idle", {7'b0, irq_ab}, 8'h00);
    wr(A_EN[1], 8'h00);

    // data and direction on port F
    wr(A_DIR[2], 8'h0F);
    wr(A_DAT[2], 8'h35);
    pf = 8'hA0;
    wait_clk(4);
    chk("R9", "pad output", f_o, 8'h35);
    chk("R9", "pad output enable", f_oe, 8'h0F);
    rd(A_DAT[2], v); chk("R9", "data readback mix", v, 8'hA5);
    rd(A_DIR[2], v); chk("R10", "direction readback", v, 8'h0F);
    pf = 8'h00;

    // debounce: bit0 filtered, bit1 not
    wr(A_T1[1], 8'h03);
    wr(A_T2[1], 8'h03);
    wr(A_DB[1], 8'h01);
    wr(A_EN[1], 8'h03);
    wait_clk(10);
    rd(A_DB[1], v); chk("R10", "filter reg readback", v, 8'h01);
    pb = 8'h03;
    wait_clk(2);
    pb = 8'h00;
    wait_clk(30);
    rd(A_ST[1], v); chk("R8", "glitch passes only unfiltered pin", v, 8'h02);
    pb = 8'h03;
    wait_clk(6);
    rd(A_ST[1], v); chk("R8", "filtered pin not yet passed", v, 8'h02);
    wait_clk(34);
    rd(A_ST[1], v); chk("R8", "filtered pin passed after stable", v, 8'h03);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule